// File: doc/BRIEF.md
# Two-channel DAC power-state controller

This block keeps track of the power state of two converter output channels and of the bias generator they share. It receives single-cycle events from a command decoder that runs ahead of it: a per-channel shutdown request carrying a termination bit, a full power-down request, a per-channel register update from a serial command, and a register update caused by the asynchronous load input. From these events it drives an enable for each channel, an enable for the bias generator, a termination select for each channel, and a per-channel output-valid flag.

A channel comes back up only when a serial command writes its DAC register. A load caused by the asynchronous pin does not wake a channel. When a channel wakes, a settling counter holds its valid flag low for a number of clock cycles. The interval is longer when the bias generator also had to be restarted, and shorter when only the channel itself was shut down. Both intervals are parameters counted in cycles of the free-running clock.

Top module: `dacpwr_ctrl`

## Requirements
- R1: After reset both channels are enabled, the bias enable is 1, every termination field is 00 and both valid flags are 0. Each valid flag then rises SETTLE_FULL cycles after the internal reset releases. The internal reset is synchronized by two flops.
- R2: A shutdown request for one channel clears that channel's enable and valid flag on the next cycle. The other channel and the bias enable keep their values.
- R3: The termination select of channel i is the field term_sel[2i+1:2i]. It reads 00 while the channel is enabled. While the channel is shut down it reads 01 (1k to ground) if the latched load bit was 0, and 10 (200k to ground) if the latched load bit was 1. The load bit is latched from shdn_load[i] by every shutdown or full power-down event.
- R4: A full power-down request clears the bias enable and both channel enables on the next cycle. Each channel latches its own load bit. The bias enable is never 1 while both channels are shut down after a full power-down.
- R5: A serial register update for a channel that is shut down enables that channel on the next cycle and turns the bias enable back on. The other channel keeps its state.
- R6: While the bias is off, shutdown requests, including one for both channels, only change the termination fields. The bias enable stays 0 until a channel is woken.
- R7: An update caused by the asynchronous load input changes no enable, valid flag, termination field or bias enable.
- R8: A channel's valid flag goes high SETTLE_FULL cycles after its enable rises if the bias was off when it woke, and SETTLE_CH cycles after its enable rises if the bias was on. An update to a channel that is already enabled leaves its valid flag unchanged.
- R9: Every wake reloads the whole settling interval, even if an earlier countdown for that channel had not finished.
- R10: When events for a channel arrive in the same cycle, full power-down wins over shutdown, and shutdown wins over update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| shdn_req | input | NCH | Per-channel shutdown request, one-cycle pulse |
| shdn_load | input | NCH | Termination bit per channel for a shutdown or full power-down (0 = 1k, 1 = 200k) |
| full_pd | input | 1 | Full power-down request: bias and all channels off |
| upd_req | input | NCH | Per-channel register update from a serial command (wakes the channel) |
| ext_load | input | 1 | Register update from the asynchronous load input (never wakes) |
| bias_en | output | 1 | Enable of the shared bias generator |
| ch_en | output | NCH | Per-channel amplifier enable |
| term_sel | output | 2*NCH | Termination select, two bits per channel (00 none, 01 1k, 10 200k) |
| out_valid | output | NCH | Per-channel flag: output has settled |

## Verification
The bench first targets the choice of settling length. It wakes one channel out of full power-down and another channel out of a plain shutdown, and checks the exact cycle in which each valid flag rises. A design that picked the interval from the wrong bias state would raise the flag 15 cycles early or late. It then shuts both channels down while the bias is off, and fires asynchronous-load events both with the bias on and with it off. A design that woke the bias or a channel on either of these would show a 1 on bias_en or ch_en. Last, it aborts a countdown midway, wakes the channel again and then sends colliding requests. A design that kept the old count, or ordered the priority wrongly, would show an early valid flag or the wrong enable after the collision.

// File: rtl/dacpwr_pkg.sv
package dacpwr_pkg;

  // termination select encoding per channel
  typedef enum logic [1:0] {
    TERM_NONE = 2'b00,
    TERM_1K   = 2'b01,
    TERM_200K = 2'b10
  } term_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacpwr_rst_sync.sv
module dacpwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dacpwr_bias.sv
module dacpwr_bias (
  input  logic clk,
  input  logic rst_n,
  input  logic full_pd,
  input  logic wake_any,
  output logic bias_on
);

  logic bias_q, bias_d, bias_ce;

  always_comb begin
    bias_ce = full_pd | wake_any;
    bias_d  = !full_pd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bias_q <= 1'b1;
    else if (bias_ce) bias_q <= bias_d;
  end

  assign bias_on = bias_q;

  // R4: full power-down turns the bias off
  p_pd_bias_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_pd |=> !bias_on);

  // R6: with no wake, an off bias stays off
  p_bias_stays_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bias_on && !wake_any) |=> !bias_on);

  // R5: a wake without power-down restores the bias
  p_wake_bias_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_any && !full_pd) |=> bias_on);

endmodule

// File: rtl/dacpwr_chan.sv
module dacpwr_chan
  import dacpwr_pkg::*;
#(
  parameter int SETTLE_FULL = 3500,
  parameter int SETTLE_CH   = 3000,
  parameter int CW          = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn,
  input  logic       load_bit,
  input  logic       full_pd,
  input  logic       upd,
  input  logic       ext_load,
  input  logic       bias_on,
  output logic       en,
  output logic [1:0] term,
  output logic       valid
);

  logic          en_q, en_d;
  logic          ld_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;
  logic          go_down, wake;

  // next-state logic: power-down > shutdown > update
  always_comb begin
    go_down = full_pd | shdn;
    wake    = !go_down && upd && !en_q;
    en_d    = go_down ? 1'b0 : (wake ? 1'b1 : en_q);
    cnt_ce  = wake || (en_q && (cnt_q != '0));
    if (wake) cnt_d = bias_on ? CW'(SETTLE_CH) : CW'(SETTLE_FULL);
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      ld_q  <= 1'b0;
      cnt_q <= CW'(SETTLE_FULL);
    end else begin
      en_q <= en_d;
      if (go_down) ld_q  <= load_bit;
      if (cnt_ce)  cnt_q <= cnt_d;
    end
  end

  assign en    = en_q;
  assign term  = en_q ? TERM_NONE : (ld_q ? TERM_200K : TERM_1K);
  assign valid = en_q && (cnt_q == '0);

  // R2: shutdown drops enable and valid
  p_shdn_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> (!en && !valid));

  // R5: an update that is not overridden leaves the channel enabled
  p_upd_wakes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !shdn && !full_pd) |=> en);

  // R7: an asynchronous-load update never wakes a shut channel
  p_ext_no_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_load && !upd && !en) |=> !en);

  // R8: a fresh wake is never valid at once
  p_wake_not_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !shdn && !full_pd && !en) |=> !valid);

  // R8: a settled channel stays valid unless shut down
  p_valid_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !shdn && !full_pd) |=> valid);

  // R3: a shut channel always presents a termination
  p_term_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_down |=> (term != TERM_NONE));

endmodule

// File: rtl/dacpwr_ctrl.sv
module dacpwr_ctrl
  import dacpwr_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SETTLE_FULL = 3500,
  parameter int SETTLE_CH   = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   shdn_req,
  input  logic [NCH-1:0]   shdn_load,
  input  logic             full_pd,
  input  logic [NCH-1:0]   upd_req,
  input  logic             ext_load,
  output logic             bias_en,
  output logic [NCH-1:0]   ch_en,
  output logic [2*NCH-1:0] term_sel,
  output logic [NCH-1:0]   out_valid
);

  localparam int MAXS = max_i(SETTLE_FULL, SETTLE_CH);
  localparam int CW   = $clog2(MAXS + 1);

  logic rst_sync_n;
  logic wake_any;

  dacpwr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wake_any = !full_pd && (|(upd_req & ~shdn_req & ~ch_en));

  dacpwr_bias i_bias (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .full_pd  (full_pd),
    .wake_any (wake_any),
    .bias_on  (bias_en)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [1:0] term_w;
    dacpwr_chan #(
      .SETTLE_FULL (SETTLE_FULL),
      .SETTLE_CH   (SETTLE_CH),
      .CW          (CW)
    ) i_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .shdn     (shdn_req[g]),
      .load_bit (shdn_load[g]),
      .full_pd  (full_pd),
      .upd      (upd_req[g]),
      .ext_load (ext_load),
      .bias_on  (bias_en),
      .en       (ch_en[g]),
      .term     (term_w),
      .valid    (out_valid[g])
    );
    assign term_sel[2*g +: 2] = term_w;
  end

  // R4: no channel runs while the bias is off
  p_bias_off_no_chan_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bias_en |-> (ch_en == '0));

endmodule

// File: tb/test_dacpwr_ctrl.sv
module test_dacpwr_ctrl;

  localparam int F = 40;
  localparam int C = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] shdn_req = '0, shdn_load = '0, upd_req = '0;
  logic       full_pd = 1'b0, ext_load = 1'b0;
  logic       bias_en;
  logic [1:0] ch_en, out_valid;
  logic [3:0] term_sel;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int         at;
    logic [1:0] en;
    logic [3:0] tm;
    logic [1:0] v;
    logic       b;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  dacpwr_ctrl #(.NCH(2), .SETTLE_FULL(F), .SETTLE_CH(C)) i_dacpwr_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .shdn_req  (shdn_req),
    .shdn_load (shdn_load),
    .full_pd   (full_pd),
    .upd_req   (upd_req),
    .ext_load  (ext_load),
    .bias_en   (bias_en),
    .ch_en     (ch_en),
    .term_sel  (term_sel),
    .out_valid (out_valid)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input exp_t e);
    total++;
    if (ch_en !== e.en || term_sel !== e.tm || out_valid !== e.v || bias_en !== e.b) begin
      bad++;
      $display("FAIL %s cyc=%0d: en=%b term=%b valid=%b bias=%b expected en=%b term=%b valid=%b bias=%b",
               e.tag, cyc, ch_en, term_sel, out_valid, bias_en, e.en, e.tm, e.v, e.b);
    end
  endtask

  // monitor: pops every expectation due in this cycle
  initial begin
    forever begin
      @(negedge clk);
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
        if (sb_q[i].at == cyc) begin
          compare(sb_q[i]);
          sb_q.delete(i);
        end else if (sb_q[i].at < cyc) begin
          total++; bad++;
          $display("FAIL %s: expectation for cycle %0d missed", sb_q[i].tag, sb_q[i].at);
          sb_q.delete(i);
        end
      end
    end
  end

  task automatic expect_at(input int dly, input logic [1:0] en, input logic [3:0] tm,
                           input logic [1:0] v, input logic b, input string tag);
    exp_t e;
    e.at = cyc + dly; e.en = en; e.tm = tm; e.v = v; e.b = b; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // driver: one-cycle event, expected state one cycle later
  task automatic step(input logic [1:0] sd, input logic [1:0] ld, input logic pd,
                      input logic [1:0] up, input logic ex,
                      input logic [1:0] en, input logic [3:0] tm,
                      input logic [1:0] v, input logic b, input string tag);
    shdn_req = sd; shdn_load = ld; full_pd = pd; upd_req = up; ext_load = ex;
    expect_at(1, en, tm, v, b, tag);
    @(negedge clk);
    shdn_req = '0; shdn_load = '0; full_pd = 1'b0; upd_req = '0; ext_load = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    exp_t r;
    idle(3);
    r.at = cyc; r.en = 2'b11; r.tm = 4'b0000; r.v = 2'b00; r.b = 1'b1; r.tag = "R1 reset state";
    compare(r);
    rst_n = 1'b1;
    expect_at(F + 1, 2'b11, 4'b0000, 2'b00, 1'b1, "R1 still settling");
    expect_at(F + 2, 2'b11, 4'b0000, 2'b11, 1'b1, "R1 settled after reset");
    idle(F + 3);

    step(2'b01, 2'b00, 0, 2'b00, 0, 2'b10, 4'b0001, 2'b10, 1, "R2 R3 shutdown A 1k");
    step(2'b10, 2'b10, 0, 2'b00, 0, 2'b00, 4'b1001, 2'b00, 1, "R2 R3 R6 shutdown B 200k bias on");

    step(2'b00, 2'b00, 0, 2'b01, 0, 2'b01, 4'b1000, 2'b00, 1, "R5 wake A");
    expect_at(C - 1, 2'b01, 4'b1000, 2'b00, 1, "R8 short settle not done");
    expect_at(C,     2'b01, 4'b1000, 2'b01, 1, "R8 short settle done");
    idle(C + 1);

    step(2'b00, 2'b00, 0, 2'b00, 1, 2'b01, 4'b1000, 2'b01, 1, "R7 ext load bias on");
    step(2'b00, 2'b00, 0, 2'b01, 0, 2'b01, 4'b1000, 2'b01, 1, "R8 update on running channel");

    step(2'b00, 2'b01, 1, 2'b00, 0, 2'b00, 4'b0110, 2'b00, 0, "R4 full power-down");
    step(2'b01, 2'b00, 0, 2'b00, 0, 2'b00, 4'b0101, 2'b00, 0, "R6 shutdown A bias off");
    step(2'b11, 2'b11, 0, 2'b00, 0, 2'b00, 4'b1010, 2'b00, 0, "R6 shutdown both bias off");
    step(2'b00, 2'b00, 0, 2'b00, 1, 2'b00, 4'b1010, 2'b00, 0, "R7 ext load bias off");

    step(2'b00, 2'b00, 0, 2'b10, 0, 2'b10, 4'b0010, 2'b00, 1, "R5 wake B from power-down");
    expect_at(F - 1, 2'b10, 4'b0010, 2'b00, 1, "R8 long settle not done");
    expect_at(F,     2'b10, 4'b0010, 2'b10, 1, "R8 long settle done");
    idle(F + 1);

    step(2'b00, 2'b00, 0, 2'b01, 0, 2'b11, 4'b0000, 2'b10, 1, "R5 wake A bias on");
    expect_at(C - 1, 2'b11, 4'b0000, 2'b10, 1, "R8 A short not done");
    expect_at(C,     2'b11, 4'b0000, 2'b11, 1, "R8 A short done");
    idle(C + 1);

    step(2'b01, 2'b00, 0, 2'b00, 0, 2'b10, 4'b0001, 2'b10, 1, "R9 shutdown A");
    step(2'b00, 2'b00, 0, 2'b01, 0, 2'b11, 4'b0000, 2'b10, 1, "R9 first wake A");
    idle(10);
    step(2'b01, 2'b01, 0, 2'b00, 0, 2'b10, 4'b0010, 2'b10, 1, "R9 abort countdown");
    step(2'b00, 2'b00, 0, 2'b01, 0, 2'b11, 4'b0000, 2'b10, 1, "R9 second wake A");
    expect_at(C - 1, 2'b11, 4'b0000, 2'b10, 1, "R9 full interval reloaded");
    expect_at(C,     2'b11, 4'b0000, 2'b11, 1, "R9 valid after reload");
    idle(C + 1);

    step(2'b01, 2'b01, 0, 2'b01, 0, 2'b10, 4'b0010, 2'b10, 1, "R10 shutdown beats update");
    step(2'b01, 2'b00, 1, 2'b11, 0, 2'b00, 4'b0101, 2'b00, 0, "R10 power-down beats all");

    step(2'b00, 2'b00, 0, 2'b11, 0, 2'b11, 4'b0000, 2'b00, 1, "R5 wake both");
    expect_at(F - 1, 2'b11, 4'b0000, 2'b00, 1, "R8 both long not done");
    expect_at(F,     2'b11, 4'b0000, 2'b11, 1, "R8 both long done");
    idle(F + 3);

    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R1 scoreboard: %0d expectations left, expected 0", sb_q.size());
    end
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R1 watchdog: run hung, got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule